// File: doc/BRIEF.md
# Processor Supervisor with Failover Flag

This block watches over a processor from a single cycle clock. It keeps the processor's reset asserted while a synchronous power-good input is low. Once power is good, it holds reset for a programmable number of cycles before it lets go. While the processor runs, it must pulse a kick input low at regular intervals. If no accepted kick arrives inside a programmable number of cycles, the block pulls reset low again for the full hold period. Kicks that arrive while reset is low are ignored. The kick pin is asynchronous: it passes through a synchronizer, and then a filter rejects low pulses narrower than a programmable width.

A second active-low output, the failover flag, tells backup logic to take over. It goes low on the third watchdog fault in a row with no accepted kick between them. It goes back high only after three accepted kicks in a row, each one arriving while the processor runs. A power-good drop releases the flag at once.

The controller has three states:
- `ST_PWR_LOW` holds reset while power is bad.
- `ST_HOLD` stretches reset.
- `ST_RUN` releases reset and times the kicks.

It has five transitions:
- *power-lost*: any state goes to `ST_PWR_LOW` when power-good is sampled low.
- *power-up*: `ST_PWR_LOW` goes to `ST_HOLD`.
- *release*: `ST_HOLD` goes to `ST_RUN` when the hold count ends.
- *kick*: `ST_RUN` stays in `ST_RUN` and its count restarts.
- *timeout*: `ST_RUN` goes to `ST_HOLD` when the watchdog count runs out.

Top module: `proc_supervisor`

## Requirements
- R1: A clock edge that samples `pwr_good` low drives `sys_rst_n` low in the following cycle, from any state.
- R2: After the edge that first samples `pwr_good` high, `sys_rst_n` stays low for `rst_period` cycles and then goes high. A `rst_period` of 0 acts as 1.
- R3: If no kick is accepted for `wd_period` cycles while `sys_rst_n` is high, `sys_rst_n` goes low on the next edge and stays low for `rst_period` cycles.
- R4: The watchdog count is held at zero while reset is low and starts from zero at the release edge. The first timeout therefore falls exactly `wd_period` cycles after release.
- R5: A kick accepted while `sys_rst_n` is low has no effect on the watchdog count and is not counted as a good kick by the failover logic.
- R6: An accepted kick while `sys_rst_n` is high restarts the watchdog count. Kicks spaced closer than `wd_period` keep reset high indefinitely.
- R7: `failover_n` goes low on the same edge as the third consecutive watchdog timeout that had no good kick between them.
- R8: `failover_n` returns high on the third consecutive good kick. A timeout between good kicks restarts that count.
- R9: While `pwr_good` is low, `failover_n` is high and both counts are cleared. `failover_n` goes high in the cycle after `pwr_good` is sampled low.
- R10: `kick` passes through two synchronizing flops. A low level shorter than `kick_min_width` cycles is rejected, and a low level of at least `kick_min_width` cycles is accepted as one kick. A width of 0 acts as 1.
- R11: A `wd_period` of 0 disables the watchdog: no timeout ever occurs, and only power-good drives reset.
- R12: While `rst_n` is low, `sys_rst_n` is low and `failover_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pwr_good | input | 1 | Synchronous supply-good indication, high when the supply is good |
| kick | input | 1 | Asynchronous watchdog kick; a falling edge is the service event |
| wd_period | input | TW | Watchdog timeout in cycles; 0 disables the watchdog |
| rst_period | input | RW | Reset hold time in cycles |
| kick_min_width | input | KW | Minimum accepted low width of `kick`, in cycles |
| sys_rst_n | output | 1 | Active-low processor reset |
| failover_n | output | 1 | Active-low request for backup logic to take over |

## Verification
The bench keeps the default counter widths and programs a 20-cycle watchdog period, an 8-cycle hold and a 3-cycle kick filter. It also revisits a hold of 1, a filter width of 0 and a watchdog period of 0. Periods this short let a full three-timeout failover sequence, and its three-kick recovery, finish in under a hundred cycles. This makes exact cycle checks of every output change affordable. Filter widths on both sides of the threshold exercise rejection and acceptance of short kick pulses.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        ST_PWR_LOW = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RUN     = 2'd2
    } sup_state_t;
endpackage

// File: rtl/sup_kick_filter.sv
// Synchronizes the kick pin, applies a minimum-width filter and emits a
// one-cycle pulse when the filtered level falls.
module sup_kick_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int KW          = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kick_in,
    input  logic [KW-1:0] min_width,
    output logic          kick_fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ks;
    logic                   level_q;
    logic                   fall_q;
    logic [KW-1:0]          run_q;
    logic [KW:0]            run_inc;
    logic [KW:0]            limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], kick_in};
    end

    assign ks      = sync_q[SYNC_STAGES-1];
    assign run_inc = {1'b0, run_q} + {{KW{1'b0}}, 1'b1};
    assign limit   = (min_width == '0) ? {{KW{1'b0}}, 1'b1} : {1'b0, min_width};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b1;
            run_q   <= '0;
            fall_q  <= 1'b0;
        end else begin
            fall_q <= 1'b0;
            if (ks != level_q) begin
                if (run_inc >= limit) begin
                    level_q <= ks;
                    run_q   <= '0;
                    fall_q  <= ~ks;
                end else begin
                    run_q <= run_inc[KW-1:0];
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign kick_fall = fall_q;
endmodule

// File: rtl/sup_wd_fsm.sv
// Reset controller: power hold, reset stretch and watchdog timing share one counter.
module sup_wd_fsm
    import sup_pkg::*;
#(
    parameter int TW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  logic          kick_fall,
    input  logic [TW-1:0] wd_period,
    input  logic [RW-1:0] rst_period,
    output logic          sys_rst_n,
    output logic          wd_fault,
    output logic          kick_ok
);
    localparam int CW = (TW > RW) ? TW : RW;

    sup_state_t  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW:0]   cnt_inc;
    logic [CW:0]   hold_lim;
    logic [CW:0]   wd_lim;
    logic          wd_on;

    assign cnt_inc  = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
    assign hold_lim = (rst_period == '0) ? {{CW{1'b0}}, 1'b1}
                                         : (CW+1)'(rst_period);
    assign wd_lim   = (CW+1)'(wd_period);
    assign wd_on    = (wd_period != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWR_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        wd_fault = 1'b0;
        kick_ok  = 1'b0;
        unique case (state_q)
            ST_PWR_LOW: begin
                cnt_d = '0;
                if (pwr_good) state_d = ST_HOLD;          // power-up
            end
            ST_HOLD: begin
                if (cnt_inc >= hold_lim) begin            // release
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_inc[CW-1:0];
                end
            end
            ST_RUN: begin
                if (kick_fall) begin                      // kick
                    kick_ok = 1'b1;
                    cnt_d   = '0;
                end else if (wd_on && (cnt_inc >= wd_lim)) begin  // timeout
                    wd_fault = 1'b1;
                    state_d  = ST_HOLD;
                    cnt_d    = '0;
                end else if (wd_on) begin
                    cnt_d = cnt_inc[CW-1:0];
                end
            end
            default: begin
                state_d = ST_PWR_LOW;
                cnt_d   = '0;
            end
        endcase
        if (!pwr_good) begin                              // power-lost
            state_d  = ST_PWR_LOW;
            cnt_d    = '0;
            wd_fault = 1'b0;
            kick_ok  = 1'b0;
        end
    end

    // outputs
    always_comb begin
        sys_rst_n = (state_q == ST_RUN);
    end
endmodule

// File: rtl/sup_fail_tracker.sv
// Failover flag with hysteresis: set by consecutive faults, cleared by consecutive good kicks.
module sup_fail_tracker #(
    parameter int FAULT_LIMIT = 3,
    parameter int CLEAR_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic wd_fault,
    input  logic kick_ok,
    output logic failover_n
);
    localparam int FCW = $clog2(FAULT_LIMIT + 1);
    localparam int GCW = $clog2(CLEAR_LIMIT + 1);

    logic           flag_q;
    logic [FCW-1:0] fcnt_q;
    logic [GCW-1:0] gcnt_q;
    logic [FCW:0]   fcnt_inc;
    logic [GCW:0]   gcnt_inc;

    assign fcnt_inc = {1'b0, fcnt_q} + {{FCW{1'b0}}, 1'b1};
    assign gcnt_inc = {1'b0, gcnt_q} + {{GCW{1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            fcnt_q <= '0;
            gcnt_q <= '0;
        end else if (!pwr_good) begin
            flag_q <= 1'b0;
            fcnt_q <= '0;
            gcnt_q <= '0;
        end else if (wd_fault) begin
            gcnt_q <= '0;
            if (!flag_q) begin
                if (fcnt_inc >= (FCW+1)'(FAULT_LIMIT)) begin
                    flag_q <= 1'b1;
                    fcnt_q <= '0;
                end else begin
                    fcnt_q <= fcnt_inc[FCW-1:0];
                end
            end
        end else if (kick_ok) begin
            fcnt_q <= '0;
            if (flag_q) begin
                if (gcnt_inc >= (GCW+1)'(CLEAR_LIMIT)) begin
                    flag_q <= 1'b0;
                    gcnt_q <= '0;
                end else begin
                    gcnt_q <= gcnt_inc[GCW-1:0];
                end
            end
        end
    end

    assign failover_n = ~flag_q;
endmodule

// File: rtl/proc_supervisor.sv
module proc_supervisor #(
    parameter int TW          = 16,
    parameter int RW          = 16,
    parameter int KW          = 4,
    parameter int SYNC_STAGES = 2,
    parameter int FAULT_LIMIT = 3,
    parameter int CLEAR_LIMIT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  logic          kick,
    input  logic [TW-1:0] wd_period,
    input  logic [RW-1:0] rst_period,
    input  logic [KW-1:0] kick_min_width,
    output logic          sys_rst_n,
    output logic          failover_n
);
    logic kick_fall;
    logic wd_fault;
    logic kick_ok;

    sup_kick_filter #(.SYNC_STAGES(SYNC_STAGES), .KW(KW)) i_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick_in   (kick),
        .min_width (kick_min_width),
        .kick_fall (kick_fall)
    );

    sup_wd_fsm #(.TW(TW), .RW(RW)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .kick_fall  (kick_fall),
        .wd_period  (wd_period),
        .rst_period (rst_period),
        .sys_rst_n  (sys_rst_n),
        .wd_fault   (wd_fault),
        .kick_ok    (kick_ok)
    );

    sup_fail_tracker #(.FAULT_LIMIT(FAULT_LIMIT), .CLEAR_LIMIT(CLEAR_LIMIT)) i_fail (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .wd_fault   (wd_fault),
        .kick_ok    (kick_ok),
        .failover_n (failover_n)
    );
endmodule

// File: rtl/proc_supervisor_chk.sv
module proc_supervisor_chk #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_good,
    input logic          kick_fall,
    input logic [TW-1:0] wd_period,
    input logic          sys_rst_n,
    input logic          failover_n
);
    // cycles reset has been high since the last accepted kick
    logic [TW:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      hi_cnt <= '0;
        else if (!sys_rst_n || kick_fall) hi_cnt <= '0;
        else if (hi_cnt != '1)           hi_cnt <= hi_cnt + 1'b1;
    end

    p_pwr_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !sys_rst_n);

    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> $past(pwr_good));

    p_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_n && (wd_period != '0)) |-> (hi_cnt < {1'b0, wd_period}));

    p_fail_onset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(failover_n) |-> $fell(sys_rst_n));

    p_fail_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(failover_n) |-> ($past(!pwr_good) || ($past(kick_fall) && sys_rst_n)));

    p_fail_pwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> failover_n);
endmodule

bind proc_supervisor proc_supervisor_chk #(.TW(TW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .kick_fall  (kick_fall),
    .wd_period  (wd_period),
    .sys_rst_n  (sys_rst_n),
    .failover_n (failover_n)
);

// File: tb/test_proc_supervisor.sv
`timescale 1ns/1ps
module test_proc_supervisor;
    localparam int TW = 16;
    localparam int RW = 16;
    localparam int KW = 4;
    localparam int T  = 20;
    localparam int P  = 8;
    localparam int N  = 3;

    // filter vectors: {low width, accepted}
    localparam logic [8:0] VEC [5] = '{
        {8'd1, 1'b0}, {8'd2, 1'b0}, {8'd3, 1'b1}, {8'd5, 1'b1}, {8'd12, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pwr_good;
    logic          kick;
    logic [TW-1:0] wd_period;
    logic [RW-1:0] rst_period;
    logic [KW-1:0] kick_min_width;
    logic          sys_rst_n;
    logic          failover_n;

    int checks = 0;
    int errors = 0;
    int low_cnt = 0;

    always #2.5 clk = ~clk;

    proc_supervisor #(.TW(TW), .RW(RW), .KW(KW)) i_proc_supervisor (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwr_good       (pwr_good),
        .kick           (kick),
        .wd_period      (wd_period),
        .rst_period     (rst_period),
        .kick_min_width (kick_min_width),
        .sys_rst_n      (sys_rst_n),
        .failover_n     (failover_n)
    );

    always @(posedge clk) if (!sys_rst_n) low_cnt <= low_cnt + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // leaves the bench at the negedge right after reset release
    task automatic restart();
        kick = 1'b1;
        pwr_good = 1'b0;
        tick(2);
        pwr_good = 1'b1;
        tick(int'(rst_period) + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog of bench actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwr_good = 1'b0; kick = 1'b1;
        wd_period = TW'(T); rst_period = RW'(P); kick_min_width = KW'(N);
        tick(3);
        chk("R12 sys_rst_n in reset", int'(sys_rst_n), 0);
        chk("R12 failover_n in reset", int'(failover_n), 1);
        rst_n = 1'b1;
        tick(2);
        chk("R1 reset held with power low", int'(sys_rst_n), 0);

        // R2 exact hold length
        pwr_good = 1'b1;
        tick(P);
        chk("R2 still held in last hold cycle", int'(sys_rst_n), 0);
        tick(1);
        chk("R2 released after hold", int'(sys_rst_n), 1);

        // R4 / R3 exact timeout measured from release
        tick(T - 1);
        chk("R4 high through last watchdog cycle", int'(sys_rst_n), 1);
        tick(1);
        chk("R3 timeout pulls reset low", int'(sys_rst_n), 0);
        chk("R7 single fault leaves flag high", int'(failover_n), 1);
        tick(P - 1);
        chk("R3 reset held for full hold", int'(sys_rst_n), 0);
        tick(1);
        chk("R3 reset released after hold", int'(sys_rst_n), 1);

        // R1 power drop
        pwr_good = 1'b0;
        tick(1);
        chk("R1 power drop asserts reset", int'(sys_rst_n), 0);

        // R10 filter vector table
        for (int i = 0; i < 5; i++) begin
            restart();
            tick(10);
            kick = 1'b0;
            tick(int'(VEC[i][8:1]));
            kick = 1'b1;
            tick(12 - int'(VEC[i][8:1]));
            chk($sformatf("R10 kick width %0d", VEC[i][8:1]), int'(sys_rst_n), int'(VEC[i][0]));
        end

        // R10 width 0 acts as 1
        kick_min_width = '0;
        restart();
        tick(10);
        kick = 1'b0; tick(1); kick = 1'b1;
        tick(11);
        chk("R10 width 0 accepts one-cycle kick", int'(sys_rst_n), 1);
        kick_min_width = KW'(N);

        // R2 hold of 1
        rst_period = RW'(1);
        pwr_good = 1'b0; tick(2); pwr_good = 1'b1;
        tick(1);
        chk("R2 hold 1 first cycle low", int'(sys_rst_n), 0);
        tick(1);
        chk("R2 hold 1 released", int'(sys_rst_n), 1);
        rst_period = RW'(P);

        // R7 three timeouts set the flag
        restart();
        tick(3 * T + 2 * P - 1);
        chk("R7 flag high before third fault", int'(failover_n), 1);
        tick(1);
        chk("R7 flag low on third fault", int'(failover_n), 0);
        chk("R7 reset low with flag", int'(sys_rst_n), 0);

        // R5 kick during hold is ignored
        kick = 1'b0; tick(3); kick = 1'b1; tick(P - 3);
        chk("R3 released after third fault", int'(sys_rst_n), 1);
        low_cnt = 0;
        for (int j = 0; j < 2; j++) begin
            kick = 1'b0; tick(4); kick = 1'b1; tick(6);
        end
        chk("R5 hold-time kick not counted", int'(failover_n), 0);
        kick = 1'b0; tick(4); kick = 1'b1; tick(6);
        chk("R8 flag released on third good kick", int'(failover_n), 1);
        for (int j = 0; j < 5; j++) begin
            kick = 1'b0; tick(4); kick = 1'b1; tick(6);
        end
        chk("R6 periodic kicks keep reset high", low_cnt, 0);
        chk("R8 flag stays high", int'(failover_n), 1);

        // R9 power drop releases the flag
        restart();
        tick(3 * T + 2 * P);
        chk("R9 flag set before power drop", int'(failover_n), 0);
        pwr_good = 1'b0;
        tick(1);
        chk("R9 power drop releases flag", int'(failover_n), 1);
        chk("R1 power drop holds reset", int'(sys_rst_n), 0);

        // R11 watchdog disabled
        wd_period = '0;
        restart();
        low_cnt = 0;
        tick(200);
        chk("R11 no timeout when disabled", low_cnt, 0);
        chk("R11 flag untouched when disabled", int'(failover_n), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule